// File: doc/BRIEF.md
# Privileged Status and Interrupt Register Bank

This block holds the machine-level status word, the interrupt enable, pending and delegation words, the exception delegation word, the two trap vector bases and the two counter-enable words of a processor hart. A single-cycle register access port reads and writes them. Every write passes through per-register masks and field legality filters, so stored state is always legal. The supervisor status, enable and pending words are not stored separately. They are filtered views of the machine registers, and writes through them touch only the bits the view exposes.

A neighbouring trap unit reads the stored words through dedicated outputs. An instruction pipeline drives the access port. Read data and the illegal-access flag are registered, and both appear one cycle after the access. Default configuration: 32-bit data, 8-bit access address, extension-state field writable, machine vector reset value 0x100.

Top module: `pcsr_bank`

## Requirements
- R1: On synchronous reset every stored word reads zero, except the machine vector base, which takes the `RESET_VEC` parameter value (default 0x100).
- R2: Implemented addresses are 0x00 status, 0x01 enable, 0x02 pending, 0x03 interrupt delegation, 0x04 exception delegation, 0x05 machine vector, 0x06 user counter-enable, 0x07 supervisor counter-enable, 0x10 supervisor status view, 0x11 supervisor enable view, 0x12 supervisor pending view and 0x15 supervisor vector. An access to any other address sets `csr_illegal` for exactly the following cycle, returns zero read data and changes no register.
- R3: `csr_rdata` is valid in the cycle after an access and holds the value the register had before any write made by that same access.
- R4: A machine status write stores only the following fields: SIE bit 0, MIE bit 1, SPIE bit 2, MPIE bit 3, SPP bit 4, FS bits 8:7, XS bits 10:9 (only when `HAS_EXT`=1), MPRV bit 11 and PUM bit 12. The other bits stay zero, apart from MPP, VM and SD.
- R5: The previous-privilege field MPP (bits 6:5) takes the written value only when that value is 0, 1 or 3. A written value of 2 leaves the field unchanged.
- R6: The translation-mode field VM (bits 20:16) takes the written value only when that value is legal for `XLEN`: 0 is always legal, 8 is legal only at 32 bits, and 9 or 10 are legal only at 64 bits. Any other value leaves the field unchanged.
- R7: The top status bit SD (bit XLEN-1) is recomputed on every status write. It is 1 when FS is 3 or XS is 3, and 0 otherwise.
- R8: A machine pending write stores only bit 1 (supervisor software) and bit 5 (supervisor timer). All other pending bits read zero.
- R9: The interrupt delegation word stores only bits 1, 5 and 9. The enable word stores bits 1, 5 and 9 plus bit 3 (machine software) and bit 7 (machine timer).
- R10: The supervisor enable and pending views read as the machine word ANDed with the delegation word. A write through a view changes only the bits that are set in the delegation word, and the masks of R8 and R9 still apply.
- R11: The supervisor status view reads SIE, SPIE, SPP, FS, XS and PUM from the status word, plus SD. A write through it changes only those six fields, and SD is then recomputed.
- R12: Writes to either vector base clear bits 1:0. Each counter-enable word keeps only its low 3 bits.
- R13: The exception delegation word stores only the bits set in the `EDELEG_MASK` parameter (default 0xB3FF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | Access strobe for one cycle |
| csr_we | input | 1 | Write qualifier for the access |
| csr_addr | input | AW | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Registered read data (pre-write value) |
| csr_illegal | output | 1 | One-cycle flag for an unimplemented address |
| stat_o | output | XLEN | Stored machine status word |
| ien_o | output | XLEN | Stored interrupt enable word |
| ipend_o | output | XLEN | Stored interrupt pending word |
| ideleg_o | output | XLEN | Interrupt delegation word |
| edeleg_o | output | XLEN | Exception delegation word |
| mvec_o | output | XLEN | Machine trap vector base |
| svec_o | output | XLEN | Supervisor trap vector base |

## Verification
The checker tests invariants on every cycle: MPP never holds the reserved value, VM always holds a mode that is legal for the width, SD agrees with FS and XS, the pending, enable and delegation words never hold bits outside their masks, the vectors stay aligned, and an illegal access leaves the status word unchanged and returns zero. The bench scenarios are needed for the behaviours that depend on history. These are a rejected MPP or VM value keeping its earlier value, view writes that depend on the current delegation word, pre-write read data, and the reset value of the vector. A reference model in the bench covers them across directed and random accesses.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;

  // register addresses (8-bit map)
  localparam logic [7:0] A_STAT   = 8'h00;
  localparam logic [7:0] A_IEN    = 8'h01;
  localparam logic [7:0] A_IPEND  = 8'h02;
  localparam logic [7:0] A_IDELEG = 8'h03;
  localparam logic [7:0] A_EDELEG = 8'h04;
  localparam logic [7:0] A_MVEC   = 8'h05;
  localparam logic [7:0] A_UCEN   = 8'h06;
  localparam logic [7:0] A_SCEN   = 8'h07;
  localparam logic [7:0] A_SSTAT  = 8'h10;
  localparam logic [7:0] A_SIEN   = 8'h11;
  localparam logic [7:0] A_SPEND  = 8'h12;
  localparam logic [7:0] A_SVEC   = 8'h15;

  // status field positions
  localparam int MPP_LO = 5;
  localparam int MPP_HI = 6;
  localparam int FS_LO  = 7;
  localparam int FS_HI  = 8;
  localparam int XS_LO  = 9;
  localparam int XS_HI  = 10;
  localparam int VM_LO  = 16;
  localparam int VM_HI  = 20;

  localparam logic [1:0] PRIV_RSVD = 2'd2;

  // translation mode codes
  localparam logic [4:0] VM_BARE = 5'd0;
  localparam logic [4:0] VM_P32  = 5'd8;
  localparam logic [4:0] VM_P39  = 5'd9;
  localparam logic [4:0] VM_P48  = 5'd10;

  // write masks
  localparam logic [63:0] MWR_MASK_EXT   = 64'h1F9F;
  localparam logic [63:0] MWR_MASK_NOEXT = 64'h199F;
  localparam logic [63:0] SVIEW_MASK     = 64'h1795;
  localparam logic [63:0] IRQ_DELEG_MASK = 64'h222;
  localparam logic [63:0] IRQ_EN_MASK    = 64'h2AA;
  localparam logic [63:0] IRQ_PEND_MASK  = 64'h22;
  localparam logic [63:0] CEN_MASK       = 64'h7;

  typedef struct packed {
    logic stat;
    logic ien;
    logic ipend;
    logic ideleg;
    logic edeleg;
    logic mvec;
    logic ucen;
    logic scen;
    logic sstat;
    logic sien;
    logic spend;
    logic svec;
  } sel_t;

  function automatic logic vm_legal(input int xlen, input logic [4:0] v);
    return (v == VM_BARE) ||
           ((xlen == 32) && (v == VM_P32)) ||
           ((xlen == 64) && ((v == VM_P39) || (v == VM_P48)));
  endfunction

endpackage

// File: rtl/pcsr_decode.sv
module pcsr_decode
  import pcsr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  output sel_t          sel,
  output logic          hit
);

  always_comb begin
    sel = '0;
    hit = 1'b1;
    case (addr)
      AW'(A_STAT):   sel.stat   = 1'b1;
      AW'(A_IEN):    sel.ien    = 1'b1;
      AW'(A_IPEND):  sel.ipend  = 1'b1;
      AW'(A_IDELEG): sel.ideleg = 1'b1;
      AW'(A_EDELEG): sel.edeleg = 1'b1;
      AW'(A_MVEC):   sel.mvec   = 1'b1;
      AW'(A_UCEN):   sel.ucen   = 1'b1;
      AW'(A_SCEN):   sel.scen   = 1'b1;
      AW'(A_SSTAT):  sel.sstat  = 1'b1;
      AW'(A_SIEN):   sel.sien   = 1'b1;
      AW'(A_SPEND):  sel.spend  = 1'b1;
      AW'(A_SVEC):   sel.svec   = 1'b1;
      default:       hit        = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcsr_mreg.sv
module pcsr_mreg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] RST_M = RST & MASK;

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_M;
    else if (we) q <= d & MASK;
  end

endmodule

// File: rtl/pcsr_status.sv
module pcsr_status
  import pcsr_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_m,
  input  logic            wr_s,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] stat
);

  localparam logic [XLEN-1:0] S_MASK = XLEN'(SVIEW_MASK);
  localparam logic [XLEN-1:0] M_MASK = XLEN'(HAS_EXT ? MWR_MASK_EXT : MWR_MASK_NOEXT);

  logic [XLEN-1:0] merged;
  logic [XLEN-1:0] nxt;

  always_comb begin
    merged = wr_s ? ((stat & ~S_MASK) | (wdata & S_MASK)) : wdata;
    nxt    = (stat & ~M_MASK) | (merged & M_MASK);
    if (vm_legal(XLEN, merged[VM_HI:VM_LO]))
      nxt[VM_HI:VM_LO] = merged[VM_HI:VM_LO];
    if (merged[MPP_HI:MPP_LO] != PRIV_RSVD)
      nxt[MPP_HI:MPP_LO] = merged[MPP_HI:MPP_LO];
    nxt[XLEN-1] = (&nxt[FS_HI:FS_LO]) | (&nxt[XS_HI:XS_LO]);
  end

  always_ff @(posedge clk) begin
    if (rst)              stat <= '0;
    else if (wr_m | wr_s) stat <= nxt;
  end

endmodule

// File: rtl/pcsr_bank.sv
module pcsr_bank
  import pcsr_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          AW          = 8,
  parameter bit          HAS_EXT     = 1'b1,
  parameter logic [63:0] RESET_VEC   = 64'h100,
  parameter logic [63:0] EDELEG_MASK = 64'hB3FF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_en,
  input  logic            csr_we,
  input  logic [AW-1:0]   csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic [XLEN-1:0] stat_o,
  output logic [XLEN-1:0] ien_o,
  output logic [XLEN-1:0] ipend_o,
  output logic [XLEN-1:0] ideleg_o,
  output logic [XLEN-1:0] edeleg_o,
  output logic [XLEN-1:0] mvec_o,
  output logic [XLEN-1:0] svec_o
);

  localparam logic [XLEN-1:0] S_MASK   = XLEN'(SVIEW_MASK);
  localparam logic [XLEN-1:0] SD_BIT   = XLEN'(1) << (XLEN - 1);
  localparam logic [XLEN-1:0] VEC_MASK = ~XLEN'(3);
  localparam int              NCEN     = 2;

  sel_t            sel;
  logic            hit;
  logic            wr;
  logic [XLEN-1:0] ien_d, pend_d;
  logic [XLEN-1:0] cen_q [NCEN];
  logic [NCEN-1:0] cen_we;
  logic [XLEN-1:0] rv;

  pcsr_decode #(.AW(AW)) u_dec (
    .addr (csr_addr),
    .sel  (sel),
    .hit  (hit)
  );

  assign wr = csr_en & csr_we & hit;

  pcsr_status #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_stat (
    .clk   (clk),
    .rst   (rst),
    .wr_m  (wr & sel.stat),
    .wr_s  (wr & sel.sstat),
    .wdata (csr_wdata),
    .stat  (stat_o)
  );

  // supervisor views merge through the delegation word
  always_comb begin
    ien_d  = sel.sien  ? ((ien_o   & ~ideleg_o) | (csr_wdata & ideleg_o)) : csr_wdata;
    pend_d = sel.spend ? ((ipend_o & ~ideleg_o) | (csr_wdata & ideleg_o)) : csr_wdata;
  end

  pcsr_mreg #(.W(XLEN), .MASK(XLEN'(IRQ_EN_MASK))) u_ien (
    .clk (clk), .rst (rst), .we (wr & (sel.ien | sel.sien)),
    .d (ien_d), .q (ien_o)
  );

  pcsr_mreg #(.W(XLEN), .MASK(XLEN'(IRQ_PEND_MASK))) u_pend (
    .clk (clk), .rst (rst), .we (wr & (sel.ipend | sel.spend)),
    .d (pend_d), .q (ipend_o)
  );

  pcsr_mreg #(.W(XLEN), .MASK(XLEN'(IRQ_DELEG_MASK))) u_ideleg (
    .clk (clk), .rst (rst), .we (wr & sel.ideleg),
    .d (csr_wdata), .q (ideleg_o)
  );

  pcsr_mreg #(.W(XLEN), .MASK(XLEN'(EDELEG_MASK))) u_edeleg (
    .clk (clk), .rst (rst), .we (wr & sel.edeleg),
    .d (csr_wdata), .q (edeleg_o)
  );

  pcsr_mreg #(.W(XLEN), .MASK(VEC_MASK), .RST(XLEN'(RESET_VEC))) u_mvec (
    .clk (clk), .rst (rst), .we (wr & sel.mvec),
    .d (csr_wdata), .q (mvec_o)
  );

  pcsr_mreg #(.W(XLEN), .MASK(VEC_MASK)) u_svec (
    .clk (clk), .rst (rst), .we (wr & sel.svec),
    .d (csr_wdata), .q (svec_o)
  );

  assign cen_we = {wr & sel.scen, wr & sel.ucen};

  generate
    for (genvar i = 0; i < NCEN; i++) begin : g_cen
      pcsr_mreg #(.W(XLEN), .MASK(XLEN'(CEN_MASK))) u_cen (
        .clk (clk), .rst (rst), .we (cen_we[i]),
        .d (csr_wdata), .q (cen_q[i])
      );
    end
  endgenerate

  always_comb begin
    rv = '0;
    unique case (1'b1)
      sel.stat:   rv = stat_o;
      sel.ien:    rv = ien_o;
      sel.ipend:  rv = ipend_o;
      sel.ideleg: rv = ideleg_o;
      sel.edeleg: rv = edeleg_o;
      sel.mvec:   rv = mvec_o;
      sel.ucen:   rv = cen_q[0];
      sel.scen:   rv = cen_q[1];
      sel.sstat:  rv = (stat_o & S_MASK) | (stat_o & SD_BIT);
      sel.sien:   rv = ien_o & ideleg_o;
      sel.spend:  rv = ipend_o & ideleg_o;
      sel.svec:   rv = svec_o;
      default:    rv = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata   <= '0;
      csr_illegal <= 1'b0;
    end else begin
      csr_illegal <= csr_en & ~hit;
      if (csr_en) csr_rdata <= hit ? rv : '0;
    end
  end

endmodule

// File: rtl/pcsr_bank_chk.sv
module pcsr_bank_chk
  import pcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            csr_en,
  input logic [XLEN-1:0] csr_rdata,
  input logic            csr_illegal,
  input logic [XLEN-1:0] stat_o,
  input logic [XLEN-1:0] ien_o,
  input logic [XLEN-1:0] ipend_o,
  input logic [XLEN-1:0] ideleg_o,
  input logic [XLEN-1:0] mvec_o,
  input logic [XLEN-1:0] svec_o
);

  p_mpp_legal_r5: assert property (@(posedge clk) disable iff (rst)
    stat_o[MPP_HI:MPP_LO] != PRIV_RSVD);

  p_vm_legal_r6: assert property (@(posedge clk) disable iff (rst)
    vm_legal(XLEN, stat_o[VM_HI:VM_LO]));

  p_sd_set_r7: assert property (@(posedge clk) disable iff (rst)
    ((&stat_o[FS_HI:FS_LO]) || (&stat_o[XS_HI:XS_LO])) |-> stat_o[XLEN-1]);

  p_sd_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (!(&stat_o[FS_HI:FS_LO]) && !(&stat_o[XS_HI:XS_LO])) |-> !stat_o[XLEN-1]);

  p_pend_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (ipend_o & ~XLEN'(IRQ_PEND_MASK)) == '0);

  p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
    ((ideleg_o & ~XLEN'(IRQ_DELEG_MASK)) == '0) && ((ien_o & ~XLEN'(IRQ_EN_MASK)) == '0));

  p_vec_align_r12: assert property (@(posedge clk) disable iff (rst)
    (mvec_o[1:0] == 2'b00) && (svec_o[1:0] == 2'b00));

  p_illegal_src_r2: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> $past(csr_en));

  p_illegal_hold_r2: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> ($stable(stat_o) && (csr_rdata == '0)));

endmodule

bind pcsr_bank pcsr_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .csr_en      (csr_en),
  .csr_rdata   (csr_rdata),
  .csr_illegal (csr_illegal),
  .stat_o      (stat_o),
  .ien_o       (ien_o),
  .ipend_o     (ipend_o),
  .ideleg_o    (ideleg_o),
  .mvec_o      (mvec_o),
  .svec_o      (svec_o)
);

// File: tb/sim_pcsr_bank.sv
`timescale 1ns/1ps
module sim_pcsr_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_en = 1'b0, csr_we = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata, stat_o, ien_o, ipend_o, ideleg_o, edeleg_o, mvec_o, svec_o;
  logic        csr_illegal;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_stat, m_ien, m_pend, m_deleg, m_edeleg, m_mvec, m_svec, m_ucen, m_scen;

  localparam logic [31:0] SMASK = 32'h1795;
  localparam logic [31:0] MMASK = 32'h1F9F;

  always #4 clk = ~clk;

  pcsr_bank u0 (
    .clk(clk), .rst(rst), .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .stat_o(stat_o), .ien_o(ien_o), .ipend_o(ipend_o), .ideleg_o(ideleg_o),
    .edeleg_o(edeleg_o), .mvec_o(mvec_o), .svec_o(svec_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] stat_w(input logic [31:0] old, input logic [31:0] w);
    logic [31:0] n;
    n = (old & ~MMASK) | (w & MMASK);
    if (w[20:16] == 5'd0 || w[20:16] == 5'd8) n[20:16] = w[20:16];
    if (w[6:5] != 2'd2) n[6:5] = w[6:5];
    n[31] = (n[8:7] == 2'b11) || (n[10:9] == 2'b11);
    return n;
  endfunction

  task automatic m_read(input logic [7:0] a, output logic [31:0] v, output logic ok);
    ok = 1'b1;
    case (a)
      8'h00: v = m_stat;
      8'h01: v = m_ien;
      8'h02: v = m_pend;
      8'h03: v = m_deleg;
      8'h04: v = m_edeleg;
      8'h05: v = m_mvec;
      8'h06: v = m_ucen;
      8'h07: v = m_scen;
      8'h10: v = (m_stat & SMASK) | (m_stat & 32'h8000_0000);
      8'h11: v = m_ien & m_deleg;
      8'h12: v = m_pend & m_deleg;
      8'h15: v = m_svec;
      default: begin v = '0; ok = 1'b0; end
    endcase
  endtask

  task automatic m_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: m_stat   = stat_w(m_stat, d);
      8'h01: m_ien    = d & 32'h2AA;
      8'h02: m_pend   = d & 32'h22;
      8'h03: m_deleg  = d & 32'h222;
      8'h04: m_edeleg = d & 32'hB3FF;
      8'h05: m_mvec   = d & ~32'h3;
      8'h06: m_ucen   = d & 32'h7;
      8'h07: m_scen   = d & 32'h7;
      8'h10: m_stat   = stat_w(m_stat, (m_stat & ~SMASK) | (d & SMASK));
      8'h11: m_ien    = ((m_ien & ~m_deleg) | (d & m_deleg)) & 32'h2AA;
      8'h12: m_pend   = ((m_pend & ~m_deleg) | (d & m_deleg)) & 32'h22;
      8'h15: m_svec   = d & ~32'h3;
      default: ;
    endcase
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R4";
      8'h01, 8'h03: return "R9";
      8'h02: return "R8";
      8'h04: return "R13";
      8'h05, 8'h06, 8'h07, 8'h15: return "R12";
      8'h10: return "R11";
      8'h11, 8'h12: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check_state(input string tag);
    chk(tag, "stat", stat_o, m_stat);
    chk(tag, "ien", ien_o, m_ien);
    chk(tag, "ipend", ipend_o, m_pend);
    chk(tag, "ideleg", ideleg_o, m_deleg);
    chk(tag, "edeleg", edeleg_o, m_edeleg);
    chk(tag, "mvec", mvec_o, m_mvec);
    chk(tag, "svec", svec_o, m_svec);
  endtask

  // one access: read data checked as pre-write value (R3)
  task automatic acc(input logic [7:0] a, input logic we, input logic [31:0] d, input string tag);
    logic [31:0] er;
    logic ok;
    m_read(a, er, ok);
    @(negedge clk);
    csr_en = 1'b1; csr_we = we; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
    chk({tag, "/R3"}, "rdata", csr_rdata, er);
    chk({tag, "/R2"}, "illegal", {31'd0, csr_illegal}, {31'd0, ~ok});
    if (we && ok) m_write(a, d);
    check_state(tag);
  endtask

  initial begin
    m_stat = 0; m_ien = 0; m_pend = 0; m_deleg = 0; m_edeleg = 0;
    m_mvec = 32'h100; m_svec = 0; m_ucen = 0; m_scen = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1");
    acc(8'h05, 1'b0, 32'h0, "R1");

    // status legality
    acc(8'h00, 1'b1, 32'hFFFF_FFFF, "R4");
    chk("R5", "mpp", {30'd0, stat_o[6:5]}, 32'd3);
    chk("R6", "vm", {27'd0, stat_o[20:16]}, 32'd0);
    chk("R7", "sd", {31'd0, stat_o[31]}, 32'd1);
    acc(8'h00, 1'b1, 32'h0000_0040, "R5");
    chk("R5", "mpp kept", {30'd0, stat_o[6:5]}, 32'd3);
    acc(8'h00, 1'b1, 32'h0008_0020, "R6");
    chk("R6", "vm set", {27'd0, stat_o[20:16]}, 32'd8);
    acc(8'h00, 1'b1, 32'h0009_0020, "R6");
    chk("R6", "vm kept", {27'd0, stat_o[20:16]}, 32'd8);
    chk("R7", "sd clr", {31'd0, stat_o[31]}, 32'd0);
    acc(8'h00, 1'b1, 32'h0008_0600, "R7");
    chk("R7", "sd xs", {31'd0, stat_o[31]}, 32'd1);
    acc(8'h10, 1'b1, 32'h0000_0000, "R11");
    chk("R11", "vm via view", {27'd0, stat_o[20:16]}, 32'd8);

    // pending, enable, delegation, views
    acc(8'h02, 1'b1, 32'hFFFF_FFFF, "R8");
    acc(8'h12, 1'b1, 32'h0, "R10");
    chk("R10", "spend no deleg", ipend_o, 32'h22);
    acc(8'h03, 1'b1, 32'hFFFF_FFFF, "R9");
    acc(8'h01, 1'b1, 32'hFFFF_FFFF, "R9");
    acc(8'h03, 1'b1, 32'h0000_0002, "R9");
    acc(8'h11, 1'b1, 32'h0, "R10");
    chk("R10", "sien partial", ien_o, 32'h2A8);
    acc(8'h12, 1'b1, 32'h0, "R10");
    acc(8'h11, 1'b0, 32'h0, "R10");

    // vectors, counter enables, exception delegation
    acc(8'h05, 1'b1, 32'h1237, "R12");
    acc(8'h15, 1'b1, 32'hFFFF_FFFF, "R12");
    acc(8'h06, 1'b1, 32'hFF, "R12");
    acc(8'h06, 1'b0, 32'h0, "R12");
    acc(8'h07, 1'b1, 32'h5, "R12");
    acc(8'h04, 1'b1, 32'hFFFF_FFFF, "R13");

    // illegal addresses
    acc(8'hFF, 1'b1, 32'hFFFF_FFFF, "R2");
    acc(8'h08, 1'b1, 32'h0, "R2");
    acc(8'h13, 1'b0, 32'h0, "R2");

    // random mix
    for (int i = 0; i < 800; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      int r;
      logic [7:0] legal [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
                                 8'h06, 8'h07, 8'h10, 8'h11, 8'h12, 8'h15};
      r = int'($urandom % 16);
      a = (r < 12) ? legal[r] : 8'($urandom);
      d = $urandom;
      acc(a, 1'($urandom), d, tag_of(a));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule